// File: doc/BRIEF.md
# Reflected-Code Toggle Counter

This block is a three-bit synchronous counter that runs through all eight codes of a reflected binary (Gray) cycle. From zero, one full lap is 000, 001, 011, 010, 110, 111, 101, 100, and then it wraps to 000. Exactly one output bit changes on each rising clock edge. This makes the count safe to sample from another clock domain, and it keeps switching activity low.

Each state bit is held in its own toggle flip-flop. A small sum-of-products network looks at the present state and decides which single bit flips next. An asynchronous, active-low reset forces the state to 000. Counting starts again from 000 on the first rising edge after the reset is released. The outputs are the state bits themselves, with no decoding after the flops.

Top module: `rgc_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 000, and this takes effect without waiting for a clock edge.
- R2: On each rising edge with `rst_n` high, `q` moves to its successor in the cycle 000→001→011→010→110→111→101→100→000 (`q[2]` is the most significant bit).
- R3: Between consecutive rising edges out of reset, exactly one bit of `q` changes.
- R4: Each state bit is a toggle element: it inverts on a rising edge when its toggle enable is 1 and holds otherwise; bits whose enable is 0 keep their value across the edge.
- R5: Exactly one toggle enable is high in every state. Bit 0 toggles when `q` has even parity. Bit 1 toggles when the parity is odd and `q[0]`=1. Bit 2 toggles when the parity is odd and `q[0]`=0.
- R6: The cycle has period eight: every 3-bit code is visited once per lap, and `q` is back at 000 eight edges after leaving it.
- R7: Asserting reset in mid-count returns `q` to 000, and after release the first rising edge gives 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to 000 |
| q | output | 3 | Counter state, `q[2]` most significant |

## Verification
The embedded assertions check several properties on every clock. They check the single-bit step, the successor relation and the reset value at the top. They check that exactly one toggle enable is high and that it follows the parity rule inside the enable network. Inside each flop they check that the bit flips or holds as its enable dictates.

Some behaviours need whole scenarios, and only the bench's sequences can show them. These are the absolute order of the lap from a known start, the wrap back to 000 after exactly eight edges, and the fact that every code is visited. The same holds for the asynchronous reset taking hold between edges in mid-count, with the restart at 001 that follows.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    localparam int unsigned STATE_W = 3;
    typedef logic [STATE_W-1:0] state_t;

    typedef struct packed {
        logic bit_v;
    } flop_t;

    // behavioural successor: convert to binary, add one, reflect back
    function automatic state_t gray_next(state_t g);
        state_t b;
        b[STATE_W-1] = g[STATE_W-1];
        for (int i = STATE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        b = b + 1'b1;
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/rgc_toggle_net.sv
module rgc_toggle_net
    import rgc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t q,
    output state_t t
);
    state_t t_d;
    logic   hi, md, lo;

    assign hi = q[2];
    assign md = q[1];
    assign lo = q[0];

    always_comb begin
        // bit 0: states of even parity
        t_d[0] = (~hi & ~md & ~lo) | (~hi &  md &  lo)
               | ( hi & ~md &  lo) | ( hi &  md & ~lo);
        // bit 1: odd parity with lo set
        t_d[1] = (~hi & ~md &  lo) | ( hi &  md &  lo);
        // bit 2: odd parity with lo clear
        t_d[2] = (~hi &  md & ~lo) | ( hi & ~md & ~lo);
    end

    assign t = t_d;

    // R5: a single enable is active in every state
    a_r5_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(t) == 1);

    // R5: even parity always selects bit 0
    a_r5_even_low: assert property (@(posedge clk) disable iff (!rst_n)
        (^q == 1'b0) |-> (t == 3'b001));
endmodule

// File: rtl/rgc_tflop.sv
module rgc_tflop
    import rgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic t,
    output logic q
);
    flop_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (t) s_d.bit_v = ~s_q.bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.bit_v;

    // R4: enabled bit inverts on the edge
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        t |=> (q != $past(q)));

    // R4: disabled bit keeps its value
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !t |=> $stable(q));
endmodule

// File: rtl/rgc_counter.sv
module rgc_counter
    import rgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] q
);
    state_t q_q;
    state_t tog;

    rgc_toggle_net u_net (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (q_q),
        .t     (tog)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        rgc_tflop u_ff (
            .clk   (clk),
            .rst_n (rst_n),
            .t     (tog[i]),
            .q     (q_q[i])
        );
    end

    assign q = q_q;

    // R1: output is zero whenever reset is sampled low
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (q == 3'b000));

    // R2: each edge lands on the successor code
    a_r2_successor: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == gray_next($past(q))));

    // R3: a single bit differs across each edge
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(q ^ $past(q)) == 1));
endmodule

// File: tb/rgc_counter_test.sv
`timescale 1ns/1ps
module rgc_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] q;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int ref_seq[$] = '{0, 1, 3, 2, 6, 7, 5, 4};
    int idx;
    int prev;

    always #2.5 clk = ~clk;

    rgc_counter uut (.clk(clk), .rst_n(rst_n), .q(q));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one edge of counting: advance model, compare every rule
    task automatic step_and_check();
        int expv, diff, ones, want_bit;
        @(negedge clk);
        prev = ref_seq[idx];
        idx  = (idx + 1) % 8;
        expv = ref_seq[idx];
        check(int'(q) == expv, "R2 sequence", int'(q), expv);
        diff = int'(q) ^ prev;
        ones = $countones(diff[2:0]);
        check(ones == 1, "R3 one bit changed", ones, 1);
        // R5: which bit should toggle, from parity of previous state
        if (($countones(prev[2:0]) % 2) == 0) want_bit = 1;
        else if (prev[0])                     want_bit = 2;
        else                                  want_bit = 4;
        check(diff == want_bit, "R5 toggled bit", diff, want_bit);
        // R4: untouched bits held their value
        check(((int'(q) ^ prev) & ~want_bit & 7) == 0, "R4 hold",
              (int'(q) & ~want_bit & 7), (prev & ~want_bit & 7));
    endtask

    initial begin
        #100000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        bit seen[8];
        repeat (3) @(negedge clk);
        check(q == 3'b000, "R1 reset value", q, 0);

        rst_n = 1'b1;
        idx = 0;
        for (int k = 0; k < 8; k++) begin
            step_and_check();
            seen[q] = 1'b1;
        end
        check(q == 3'b000, "R6 wrap after eight", q, 0);
        for (int c = 0; c < 8; c++) check(seen[c], "R6 code visited", seen[c], 1);

        for (int k = 0; k < 13; k++) step_and_check();

        // mid-count reset, asynchronous
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(q == 3'b000, "R1 async clear", q, 0);
        @(negedge clk);
        check(q == 3'b000, "R7 held in reset", q, 0);
        rst_n = 1'b1;
        idx = 0;
        @(negedge clk);
        check(q == 3'b001, "R7 restart", q, 1);
        idx = 1;
        for (int k = 0; k < 10; k++) step_and_check();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule